// File: doc/BRIEF.md
# Inter-Processor Software Interrupt Dispatcher

This block keeps the pending state of the sixteen software interrupt numbers (0 to 15) that processors use to signal one another. A processor starts a request by writing a 32-bit command word. The word names an interrupt number, a routing mode and a list of processors. For every processor the routing selects, the block marks the number as pending. It also records which processor made the request, in a per-target, per-number bitmap of senders.

The block keeps one sender bitmap for each pair of target and number. A single number can therefore be pending from several senders at once. When a processor takes an interrupt, it names the number it is taking. The block answers with the number and the lowest-numbered waiting sender, then retires only that sender. Two byte-wide register windows let software clear or add sender bits for its own bitmaps directly. Reading either window returns the bitmap.

Choosing which pending number a processor should take is not part of this block, and neither is the bus protocol. The block presents the pending vector, and a plain write, read and take port.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset every pending bit and every sender bitmap is zero, and a take request returns the idle code 1023.
- R2: A write of the command word at offset 0xF00 uses bits 9:0 as the number and bits 25:24 as the routing mode. In routing mode 0, the targets are the processors set in list bits 23:16, and list bits at or above NUM_CPU are dropped. For each target the number becomes pending and the writer's bit is set in that target's sender bitmap.
- R3: Routing mode 1 targets every processor except the writer.
- R4: Routing mode 2 targets the writer alone.
- R5: Routing mode 3 targets every processor.
- R6: A command word whose number field (bits 9:0) is 16 or more changes no state.
- R7: A take request for a pending number returns, on ack_value, the number in bits 3:0, zeros in bits 9:4 and the lowest set sender in bits 12:10. It clears that sender's bit in the next cycle.
- R8: After a take, the number stays pending while other senders remain, and later takes report them in ascending order. The pending bit clears with the last sender.
- R9: A take request for a number that is not pending for that processor returns 1023 and changes no state.
- R10: A byte write to offset 0xF10+n (wr_data bits 7:0) clears the written bits from the writer's sender bitmap for number n. If the bitmap becomes empty, the pending bit clears.
- R11: A byte write to offset 0xF20+n sets the writer's pending bit for n and ORs the written bits into its bitmap, even when the written bits are zero. Taking a number that is pending with an empty bitmap returns sender 0 and clears the pending bit.
- R12: rd_data returns the sender bitmap of rd_cpu for number n when rd_addr is 0xF10+n or 0xF20+n, and returns zero at any other address.
- R13: Writes to any other offset, including the ordinary enable and pending registers, leave the state of the software interrupts unchanged.
- R14: When a write and a take occur in the same cycle, ack_value reflects the state before that cycle. The take's retirement is applied first and the write second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Byte offset of the write |
| wr_data | input | 32 | Write data (command word or byte in bits 7:0) |
| wr_cpu | input | log2(NUM_CPU) | Processor issuing the write |
| ack_req | input | 1 | Take request |
| ack_cpu | input | log2(NUM_CPU) | Processor taking the interrupt |
| ack_id | input | 4 | Number being taken |
| ack_value | output | 13 | Sender in 12:10 and number in 9:0, or 1023 when idle |
| rd_addr | input | 12 | Byte offset of the read |
| rd_cpu | input | log2(NUM_CPU) | Processor whose bitmap is read |
| rd_data | output | 8 | Sender bitmap, zero-extended |
| pend_o | output | NUM_CPU*16 | Pending bits, index cpu*16+number |

## Verification
The bench aims at the cases where a single number carries several senders. A design that retired every sender at once, or picked the highest sender, would report the wrong source on the second take or drop the number early. It drives a take and a set write to the same pair in one cycle. Applying the write before the retirement would lose the newly written sender. It also covers routing mode 1 with the writer's own bit set in the list, a set write with zero data, out-of-range numbers and writes to ordinary enable or pending offsets. In each of these cases a faulty decoder would create or destroy pending state.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
    localparam int SGI_NUM = 16;
    localparam int SGI_ID_W = 4;
    localparam int REG_ADDR_W = 12;
    localparam int ACK_W = 13;

    localparam logic [REG_ADDR_W-1:0] TRIG_OFFS = 12'hF00;
    localparam logic [7:0] CLR_PAGE = 8'hF1;
    localparam logic [7:0] SET_PAGE = 8'hF2;
    localparam logic [ACK_W-1:0] ACK_IDLE = 13'd1023;

    typedef enum logic [1:0] {
        ROUTE_LIST   = 2'd0,
        ROUTE_OTHERS = 2'd1,
        ROUTE_SELF   = 2'd2,
        ROUTE_ALL    = 2'd3
    } route_e;

    typedef enum logic [1:0] {
        WOP_NONE,
        WOP_TRIG,
        WOP_CLR,
        WOP_SET
    } wop_e;
endpackage

// File: rtl/sgi_addr_decode.sv
module sgi_addr_decode
    import sgi_pkg::*;
(
    input  logic                  sel,
    input  logic [REG_ADDR_W-1:0] addr,
    output wop_e                  op,
    output logic [SGI_ID_W-1:0]   page_id
);
    always_comb begin
        op      = WOP_NONE;
        page_id = addr[SGI_ID_W-1:0];
        if (sel) begin
            if (addr == TRIG_OFFS) begin
                op = WOP_TRIG;
            end else if (addr[REG_ADDR_W-1:4] == CLR_PAGE) begin
                op = WOP_CLR;
            end else if (addr[REG_ADDR_W-1:4] == SET_PAGE) begin
                op = WOP_SET;
            end
        end
    end
endmodule

// File: rtl/sgi_target_decode.sv
module sgi_target_decode
    import sgi_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int CPU_W = 2
) (
    input  logic [31:0]         cmd,
    input  logic [CPU_W-1:0]    req_cpu,
    output logic [NCPU-1:0]     tgt_mask,
    output logic [SGI_ID_W-1:0] tgt_id,
    output logic                id_ok
);
    logic [NCPU-1:0] self_bit;
    logic            unused_cmd;
    route_e          route;

    assign self_bit   = NCPU'(1) << req_cpu;
    assign route      = route_e'(cmd[25:24]);
    assign tgt_id     = cmd[SGI_ID_W-1:0];
    assign id_ok      = (cmd[9:SGI_ID_W] == '0);
    assign unused_cmd = ^{cmd[31:26], cmd[23:16], cmd[15:10]};

    always_comb begin
        case (route)
            ROUTE_LIST:   tgt_mask = cmd[16 +: NCPU];
            ROUTE_OTHERS: tgt_mask = ~self_bit;
            ROUTE_SELF:   tgt_mask = self_bit;
            default:      tgt_mask = '1;
        endcase
    end
endmodule

// File: rtl/sgi_lowest_src.sv
module sgi_lowest_src #(
    parameter int N = 4
) (
    input  logic [N-1:0] bits,
    output logic [2:0]   idx,
    output logic         any
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits[i]) begin
                idx = 3'(i);
            end
        end
    end
    assign any = |bits;
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [REG_ADDR_W-1:0]      wr_addr,
    input  logic [31:0]                wr_data,
    input  logic [CPU_W-1:0]           wr_cpu,
    input  logic                       ack_req,
    input  logic [CPU_W-1:0]           ack_cpu,
    input  logic [SGI_ID_W-1:0]        ack_id,
    output logic [ACK_W-1:0]           ack_value,
    input  logic [REG_ADDR_W-1:0]      rd_addr,
    input  logic [CPU_W-1:0]           rd_cpu,
    output logic [7:0]                 rd_data,
    output logic [NUM_CPU*SGI_NUM-1:0] pend_o
);
    typedef struct packed {
        logic [NUM_CPU-1:0][SGI_NUM-1:0]              pend;
        logic [NUM_CPU-1:0][SGI_NUM-1:0][NUM_CPU-1:0] src;
    } state_t;

    state_t st_d, st_q;

    wop_e                wop, rop;
    logic [SGI_ID_W-1:0] page_id, rd_id, tgt_id;
    logic [NUM_CPU-1:0]  tgt_mask, ack_bits, ack_left, clr_left;
    logic                tgt_id_ok, ack_any;
    logic [2:0]          ack_src;

    sgi_addr_decode u_wdec (
        .sel     (wr_en),
        .addr    (wr_addr),
        .op      (wop),
        .page_id (page_id)
    );

    sgi_addr_decode u_rdec (
        .sel     (1'b1),
        .addr    (rd_addr),
        .op      (rop),
        .page_id (rd_id)
    );

    sgi_target_decode #(.NCPU(NUM_CPU), .CPU_W(CPU_W)) u_tdec (
        .cmd      (wr_data),
        .req_cpu  (wr_cpu),
        .tgt_mask (tgt_mask),
        .tgt_id   (tgt_id),
        .id_ok    (tgt_id_ok)
    );

    assign ack_bits = st_q.src[ack_cpu][ack_id];

    sgi_lowest_src #(.N(NUM_CPU)) u_low (
        .bits (ack_bits),
        .idx  (ack_src),
        .any  (ack_any)
    );

    // Retirement of a take is applied first, then the write of the same cycle.
    always_comb begin
        st_d      = st_q;
        ack_value = ACK_IDLE;
        ack_left  = ack_bits & (ack_bits - NUM_CPU'(1));
        clr_left  = '0;
        if (ack_req && st_q.pend[ack_cpu][ack_id]) begin
            ack_value                   = {ack_src, 6'd0, ack_id};
            st_d.src[ack_cpu][ack_id]   = ack_left;
            if (ack_left == '0) begin
                st_d.pend[ack_cpu][ack_id] = 1'b0;
            end
        end
        case (wop)
            WOP_TRIG: begin
                if (tgt_id_ok) begin
                    for (int t = 0; t < NUM_CPU; t++) begin
                        if (tgt_mask[t]) begin
                            st_d.pend[t][tgt_id]         = 1'b1;
                            st_d.src[t][tgt_id][wr_cpu]  = 1'b1;
                        end
                    end
                end
            end
            WOP_CLR: begin
                clr_left = st_d.src[wr_cpu][page_id] & ~wr_data[NUM_CPU-1:0];
                st_d.src[wr_cpu][page_id] = clr_left;
                if (clr_left == '0) begin
                    st_d.pend[wr_cpu][page_id] = 1'b0;
                end
            end
            WOP_SET: begin
                st_d.pend[wr_cpu][page_id] = 1'b1;
                st_d.src[wr_cpu][page_id]  = st_d.src[wr_cpu][page_id] | wr_data[NUM_CPU-1:0];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = (rop == WOP_CLR || rop == WOP_SET) ? 8'(st_q.src[rd_cpu][rd_id]) : 8'h00;
    assign pend_o  = st_q.pend;

    // Routing mode 1 never selects the writer.
    assert_others_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wop == WOP_TRIG && wr_data[25:24] == 2'd1) |-> !tgt_mask[wr_cpu]);

    // Routing mode 2 leaves the writer's number pending next cycle.
    assert_self_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wop == WOP_TRIG && tgt_id_ok && wr_data[25:24] == 2'd2)
        |=> st_q.pend[$past(wr_cpu)][$past(tgt_id)]);

    // A take reports the number it was asked for.
    assert_ack_format_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && ack_value != ACK_IDLE) |-> (ack_value[9:0] == 10'(ack_id)));

    // The reported sender is retired.
    assert_ack_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !wr_en && st_q.pend[ack_cpu][ack_id] && ack_any)
        |=> !st_q.src[$past(ack_cpu)][$past(ack_id)][$past(ack_src)]);

    // Remaining senders keep the number pending.
    assert_ack_keep_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !wr_en && st_q.pend[ack_cpu][ack_id] && $countones(ack_bits) >= 2)
        |=> st_q.pend[$past(ack_cpu)][$past(ack_id)]);

    // Writes elsewhere leave the state alone.
    assert_other_write_ignored_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wop == WOP_NONE && !ack_req) |=> $stable(st_q));
endmodule

// File: tb/sgi_dispatch_tb.sv
`timescale 1ns/1ps
module sgi_dispatch_tb;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  wr_cpu = '0;
    logic        ack_req = 1'b0;
    logic [1:0]  ack_cpu = '0;
    logic [3:0]  ack_id = '0;
    logic [12:0] ack_value;
    logic [11:0] rd_addr = '0;
    logic [1:0]  rd_cpu = '0;
    logic [7:0]  rd_data;
    logic [NC*16-1:0] pend_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [12:0] last_ack;

    bit          m_pend [NC][16];
    bit [NC-1:0] m_src  [NC][16];

    always #2.5 clk = ~clk;

    sgi_dispatch #(.NUM_CPU(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_cpu(wr_cpu), .ack_req(ack_req), .ack_cpu(ack_cpu), .ack_id(ack_id),
        .ack_value(ack_value), .rd_addr(rd_addr), .rd_cpu(rd_cpu), .rd_data(rd_data),
        .pend_o(pend_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [NC-1:0] f_targets(input logic [31:0] d, input int req);
        case (d[25:24])
            2'd0: return d[16 +: NC];
            2'd1: return 4'hF & ~(4'h1 << req);
            2'd2: return 4'h1 << req;
            default: return 4'hF;
        endcase
    endfunction

    function automatic logic [NC*16-1:0] f_pend_vec();
        logic [NC*16-1:0] v = '0;
        for (int c = 0; c < NC; c++)
            for (int n = 0; n < 16; n++)
                v[c*16+n] = m_pend[c][n];
        return v;
    endfunction

    task automatic check_state(input string tag);
        int c, n, kind;
        logic [7:0] exp;
        chk(pend_o == f_pend_vec(), tag, pend_o, f_pend_vec());
        c = $urandom % NC;
        n = $urandom % 16;
        kind = $urandom % 3;
        rd_cpu = 2'(c);
        rd_addr = (kind == 0) ? (12'hF10 | 12'(n)) : (kind == 1) ? (12'hF20 | 12'(n)) : (12'h100 | 12'(n));
        #1;
        exp = (kind == 2) ? 8'h00 : 8'(m_src[c][n]);
        chk(rd_data == exp, "R12", rd_data, exp);
    endtask

    task automatic sweep_reads(input string tag);
        for (int c = 0; c < NC; c++) begin
            for (int n = 0; n < 16; n++) begin
                rd_cpu = 2'(c);
                rd_addr = 12'hF20 | 12'(n);
                #0.1;
                chk(rd_data == 8'(m_src[c][n]), tag, rd_data, 8'(m_src[c][n]));
            end
        end
    endtask

    // Called at a falling edge; returns at the next falling edge after state checks.
    task automatic run_cycle(input bit we, input logic [11:0] a, input logic [31:0] d, input int wc,
                             input bit ak, input int acpu, input int aid, input string tag);
        logic [12:0] exp;
        string       atag;
        int          src;
        logic [NC-1:0] tm;
        wr_en = we; wr_addr = a; wr_data = d; wr_cpu = 2'(wc);
        ack_req = ak; ack_cpu = 2'(acpu); ack_id = 4'(aid);
        #1;
        if (ak) begin
            src = -1;
            for (int i = NC - 1; i >= 0; i--)
                if (m_src[acpu][aid][i]) src = i;
            if (!m_pend[acpu][aid]) begin
                exp = 13'd1023; atag = "R9";
            end else begin
                exp = {3'((src < 0) ? 0 : src), 6'd0, 4'(aid)};
                atag = (src < 0) ? "R11" : ($countones(m_src[acpu][aid]) > 1) ? "R8" : "R7";
                if (src >= 0) m_src[acpu][aid][src] = 1'b0;
                if (m_src[acpu][aid] == '0) m_pend[acpu][aid] = 1'b0;
            end
            if (we) atag = "R14";
            last_ack = ack_value;
            chk(ack_value == exp, atag, ack_value, exp);
        end
        if (we) begin
            if (a == 12'hF00) begin
                if (d[9:4] == 0) begin
                    tm = f_targets(d, wc);
                    for (int t = 0; t < NC; t++)
                        if (tm[t]) begin
                            m_pend[t][d[3:0]] = 1'b1;
                            m_src[t][d[3:0]][wc] = 1'b1;
                        end
                end
            end else if (a[11:4] == 8'hF1) begin
                m_src[wc][a[3:0]] &= ~d[NC-1:0];
                if (m_src[wc][a[3:0]] == '0) m_pend[wc][a[3:0]] = 1'b0;
            end else if (a[11:4] == 8'hF2) begin
                m_pend[wc][a[3:0]] = 1'b1;
                m_src[wc][a[3:0]] |= d[NC-1:0];
            end
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        ack_req = 1'b0;
        check_state(tag);
        @(negedge clk);
    endtask

    function automatic logic [31:0] cmd(input int route, input int list, input int id);
        return (32'(route) << 24) | (32'(list) << 16) | 32'(id);
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int r;
        r = $urandom(32'd4242);
        for (int c = 0; c < NC; c++)
            for (int n = 0; n < 16; n++) begin
                m_pend[c][n] = 1'b0;
                m_src[c][n] = '0;
            end
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(pend_o == '0, "R1", pend_o, 0);
        sweep_reads("R1");
        run_cycle(0, 0, 0, 0, 1, 0, 0, "R1");
        chk(last_ack == 13'd1023, "R1", last_ack, 13'd1023);

        // R2 list routing, with list bits above NC dropped
        run_cycle(1, 12'hF00, cmd(0, 8'b0101, 5), 3, 0, 0, 0, "R2");
        chk(pend_o == ((64'h1 << 5) | (64'h1 << 37)), "R2", pend_o, (64'h1 << 5) | (64'h1 << 37));
        run_cycle(1, 12'hF00, cmd(0, 8'hF0, 6), 1, 0, 0, 0, "R2");
        // R3 others, writer's own bit present in list field
        run_cycle(1, 12'hF00, cmd(1, 8'h02, 2), 1, 0, 0, 0, "R3");
        // R4 self, R5 all
        run_cycle(1, 12'hF00, cmd(2, 8'h00, 9), 2, 0, 0, 0, "R4");
        run_cycle(1, 12'hF00, cmd(3, 8'h00, 14), 0, 0, 0, 0, "R5");
        // R6 number out of range
        run_cycle(1, 12'hF00, cmd(3, 8'h0F, 16), 0, 0, 0, 0, "R6");
        run_cycle(1, 12'hF00, cmd(3, 8'h0F, 10'h3FF), 2, 0, 0, 0, "R6");
        sweep_reads("R2");

        // R8 two senders on one number
        run_cycle(1, 12'hF00, cmd(0, 8'h02, 7), 2, 0, 0, 0, "R2");
        run_cycle(1, 12'hF00, cmd(0, 8'h02, 7), 0, 0, 0, 0, "R2");
        run_cycle(0, 0, 0, 0, 1, 1, 7, "R8");
        chk(last_ack == 13'h007, "R8", last_ack, 13'h007);
        chk(pend_o[16+7] == 1'b1, "R8", pend_o[16+7], 1);
        run_cycle(0, 0, 0, 0, 1, 1, 7, "R8");
        chk(last_ack == 13'h807, "R8", last_ack, 13'h807);
        chk(pend_o[16+7] == 1'b0, "R8", pend_o[16+7], 0);
        run_cycle(0, 0, 0, 0, 1, 1, 7, "R9");
        chk(last_ack == 13'd1023, "R9", last_ack, 13'd1023);

        // R10 / R11 byte windows
        run_cycle(1, 12'hF23, 32'h0D, 1, 0, 0, 0, "R11");
        run_cycle(1, 12'hF13, 32'h05, 1, 0, 0, 0, "R10");
        chk(pend_o[16+3] == 1'b1, "R10", pend_o[16+3], 1);
        run_cycle(1, 12'hF13, 32'h08, 1, 0, 0, 0, "R10");
        chk(pend_o[16+3] == 1'b0, "R10", pend_o[16+3], 0);
        run_cycle(1, 12'hF24, 32'h00, 0, 0, 0, 0, "R11");
        chk(pend_o[4] == 1'b1, "R11", pend_o[4], 1);
        run_cycle(0, 0, 0, 0, 1, 0, 4, "R11");
        chk(last_ack == 13'h004, "R11", last_ack, 13'h004);
        chk(pend_o[4] == 1'b0, "R11", pend_o[4], 0);

        // R13 ordinary register writes
        run_cycle(1, 12'hF00, cmd(3, 0, 1), 3, 0, 0, 0, "R5");
        run_cycle(1, 12'h100, 32'hFFFFFFFF, 0, 0, 0, 0, "R13");
        run_cycle(1, 12'h180, 32'hFFFFFFFF, 0, 0, 0, 0, "R13");
        run_cycle(1, 12'h200, 32'hFFFFFFFF, 1, 0, 0, 0, "R13");
        run_cycle(1, 12'h280, 32'hFFFFFFFF, 2, 0, 0, 0, "R13");
        run_cycle(1, 12'hF30, 32'hFFFFFFFF, 2, 0, 0, 0, "R13");
        sweep_reads("R13");

        // R14 take and set write on the same pair in one cycle
        run_cycle(1, 12'hF2B, 32'h02, 0, 0, 0, 0, "R11");
        run_cycle(1, 12'hF2B, 32'h02, 0, 1, 0, 11, "R14");
        chk(last_ack == 13'h40B, "R14", last_ack, 13'h40B);
        chk(pend_o[11] == 1'b1, "R14", pend_o[11], 1);

        // Random phase
        for (int k = 0; k < 3000; k++) begin
            int sel, wc, acpu, aid, id;
            bit we, ak;
            logic [11:0] a;
            logic [31:0] d;
            string tag;
            sel = $urandom % 8;
            wc = $urandom % NC;
            acpu = $urandom % NC;
            aid = $urandom % 4;
            ak = ($urandom % 2) == 1;
            we = 1'b1;
            a = 12'h000;
            d = $urandom;
            tag = "R7";
            if (sel < 3) begin
                id = (($urandom % 8) == 0) ? 16 + ($urandom % 1000) : ($urandom % 4);
                a = 12'hF00;
                d = cmd($urandom % 4, $urandom % 256, id);
                tag = (id >= 16) ? "R6" : (d[25:24] == 0) ? "R2" : (d[25:24] == 1) ? "R3" :
                      (d[25:24] == 2) ? "R4" : "R5";
            end else if (sel == 3) begin
                a = 12'hF10 | 12'($urandom % 4);
                tag = "R10";
            end else if (sel == 4) begin
                a = 12'hF20 | 12'($urandom % 4);
                tag = "R11";
            end else if (sel == 5) begin
                case ($urandom % 5)
                    0: a = 12'h100;
                    1: a = 12'h180;
                    2: a = 12'h200;
                    3: a = 12'h280;
                    default: a = 12'hF0F;
                endcase
                tag = "R13";
            end else begin
                we = 1'b0;
            end
            if (we && ak) tag = "R14";
            run_cycle(we, a, d, wc, ak, acpu, aid, tag);
        end
        sweep_reads("R12");

        finish_run();
    end
endmodule